// File: doc/BRIEF.md
# Double-Buffered Converter Code Controller

This block holds the staged settings and the live outputs of a voltage-output converter sitting behind a two-wire slave front end. The front end turns bus traffic into single-cycle strobes. There is one strobe each for the control byte, the low data byte, the high data byte, START, STOP, and the acknowledge clock edge of a broadcast quick command; that last strobe carries the broadcast's read/write flag. The block decides from these strobes when staged values reach the converter.

A complete write word stages a new code. In the default mode the staged code reaches the output on the STOP that ends the word. In the synchronous mode the code waits for a broadcast quick command with flag 1. Many devices on the same bus can then change together. A broadcast with flag 0 clears everything in either mode. The shutdown and reference-select outputs take the control byte's value only at STOP. A write word that is cut short keeps its control byte and drops its data bytes.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0, `shdn` is 0, `ref_int` is 0, and the update mode is STOP-triggered.
- R2: In the control byte, bit 0 = 1 selects synchronous update, bit 1 = 1 requests shutdown, and bit 2 = 1 selects the internal reference. Bits 7..3 have no effect.
- R3: The low data byte supplies code bits 7..0. Bits 1..0 of the high data byte supply code bits 9..8. Bits 7..2 of the high data byte are ignored.
- R4: With synchronous mode off, a STOP that follows a complete control/low/high sequence puts the staged code on `dac_code` in the cycle after `stop_evt`. `dac_code` changes at no other time except a broadcast.
- R5: With synchronous mode on, STOP leaves `dac_code` unchanged. A broadcast acknowledge with flag 1 loads the staged code one cycle later.
- R6: A broadcast acknowledge with flag 1 while synchronous mode is off changes no output.
- R7: A broadcast acknowledge with flag 0 sets the code, the shutdown flag, the reference flag and every staged value to 0, in either mode.
- R8: `shdn` and `ref_int` change only one cycle after a STOP or a clearing broadcast. At STOP they take bits 1 and 2 of the held control byte. The code held on `dac_code` survives a shutdown.
- R9: If START arrives before the high data byte, both data bytes of that word are discarded. The following STOP still applies the control byte's shutdown and reference bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| byte_data | input | 8 | Received byte, valid with a byte strobe |
| cmd_vld | input | 1 | Control byte accepted |
| lo_vld | input | 1 | Low data byte accepted |
| hi_vld | input | 1 | High data byte accepted |
| start_evt | input | 1 | START or repeated START seen |
| stop_evt | input | 1 | STOP seen |
| bcast_ack | input | 1 | Rising clock edge in the acknowledge of a broadcast quick command |
| bcast_flag | input | 1 | Read/write flag of that broadcast |
| dac_code | output | 10 | Code driven to the converter |
| shdn | output | 1 | Shutdown active |
| ref_int | output | 1 | Internal reference selected (0 = supply) |

## Verification
The bench builds the block with its default widths: a 10-bit code from 8-bit bytes and the mode, shutdown and reference bits at control-byte positions 0, 1 and 2. At these widths the high byte is only partly used, so junk in its upper six bits checks the masking. The same applies to junk in control bits 7..3. These widths also let a directed sequence move between modes within a few hundred cycles. In that time it covers a staged code that waits across STOP, a cut-off word, and a clear that arrives while shutdown and the internal reference are both active.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_CMD  = 2'd1,
      SEQ_LO   = 2'd2
   } seq_e;
endpackage

// File: rtl/dac_cmd_reg.sv
// Holds the three meaningful control bits; cleared by broadcast clear.
module dac_cmd_reg #(
   parameter int CMD_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_vld,
   input  logic             clr,
   input  logic [CMD_W-1:0] cmd_bits,
   output logic [CMD_W-1:0] cmd_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cmd_q <= '0;
      else if (clr)     cmd_q <= '0;
      else if (cmd_vld) cmd_q <= cmd_bits;
   end
endmodule

// File: rtl/dac_in_stage.sv
// Stages data bytes; commits a code only once the high byte completes the word.
module dac_in_stage
   import dac_dbuf_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_vld,
   input  logic              lo_vld,
   input  logic              hi_vld,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              clr,
   input  logic [BYTE_W-1:0] byte_in,
   output logic [CODE_W-1:0] in_code,
   output logic              word_done
);
   localparam int HI_W = CODE_W - BYTE_W;

   seq_e              seq_q;
   logic [BYTE_W-1:0] lo_q;
   logic [HI_W-1:0]   hi_bits;

   generate
      if (HI_W == BYTE_W) begin : g_full_hi
         assign hi_bits = byte_in;
      end else begin : g_part_hi
         assign hi_bits = byte_in[HI_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q     <= SEQ_IDLE;
         lo_q      <= '0;
         in_code   <= '0;
         word_done <= 1'b0;
      end else if (clr) begin
         seq_q     <= SEQ_IDLE;
         lo_q      <= '0;
         in_code   <= '0;
         word_done <= 1'b0;
      end else if (stop_evt) begin
         seq_q     <= SEQ_IDLE;
         word_done <= 1'b0;
      end else if (start_evt) begin
         seq_q     <= SEQ_IDLE;
      end else if (cmd_vld) begin
         seq_q     <= SEQ_CMD;
         word_done <= 1'b0;
      end else if (lo_vld && seq_q == SEQ_CMD) begin
         lo_q      <= byte_in;
         seq_q     <= SEQ_LO;
      end else if (hi_vld && seq_q == SEQ_LO) begin
         in_code   <= {hi_bits, lo_q};
         word_done <= 1'b1;
         seq_q     <= SEQ_IDLE;
      end
   end
endmodule

// File: rtl/dac_out_latch.sv
// Output latches: code on STOP or broadcast, control flags on STOP only.
module dac_out_latch #(
   parameter int CODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              stop_evt,
   input  logic              bcast_upd,
   input  logic              word_done,
   input  logic              sync_mode,
   input  logic              sd_req,
   input  logic              bg_req,
   input  logic [CODE_W-1:0] in_code,
   output logic [CODE_W-1:0] dac_code,
   output logic              shdn,
   output logic              ref_int
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_code <= '0;
         shdn     <= 1'b0;
         ref_int  <= 1'b0;
      end else if (clr) begin
         dac_code <= '0;
         shdn     <= 1'b0;
         ref_int  <= 1'b0;
      end else if (stop_evt) begin
         shdn    <= sd_req;
         ref_int <= bg_req;
         if (word_done && !sync_mode) dac_code <= in_code;
      end else if (bcast_upd) begin
         dac_code <= in_code;
      end
   end
endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl #(
   parameter int BYTE_W = 8,
   parameter int CODE_W = 10,
   parameter int SY_BIT = 0,
   parameter int SD_BIT = 1,
   parameter int BG_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              cmd_vld,
   input  logic              lo_vld,
   input  logic              hi_vld,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic              bcast_ack,
   input  logic              bcast_flag,
   output logic [CODE_W-1:0] dac_code,
   output logic              shdn,
   output logic              ref_int
);
   localparam int CMD_W = 3;
   localparam int I_SY  = 0;
   localparam int I_SD  = 1;
   localparam int I_BG  = 2;

   generate
      if (CODE_W <= BYTE_W || CODE_W > 2 * BYTE_W) begin : g_bad_width
         $error("dac_dbuf_ctrl: CODE_W must exceed BYTE_W and fit in two bytes");
      end
      if (SY_BIT >= BYTE_W || SD_BIT >= BYTE_W || BG_BIT >= BYTE_W ||
          SY_BIT == SD_BIT || SY_BIT == BG_BIT || SD_BIT == BG_BIT) begin : g_bad_bits
         $error("dac_dbuf_ctrl: control bit positions must be distinct and inside a byte");
      end
   endgenerate

   logic [CMD_W-1:0]  cmd_q;
   logic [CODE_W-1:0] in_code;
   logic              word_done;
   logic              sy_mode;
   logic              bc_clr;
   logic              bc_upd;

   assign bc_clr  = bcast_ack && !bcast_flag;
   assign sy_mode = cmd_q[I_SY];
   assign bc_upd  = bcast_ack && bcast_flag && sy_mode;

   dac_cmd_reg #(.CMD_W(CMD_W)) u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_vld  (cmd_vld),
      .clr      (bc_clr),
      .cmd_bits ({byte_data[BG_BIT], byte_data[SD_BIT], byte_data[SY_BIT]}),
      .cmd_q    (cmd_q)
   );

   dac_in_stage #(.BYTE_W(BYTE_W), .CODE_W(CODE_W)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_vld   (cmd_vld),
      .lo_vld    (lo_vld),
      .hi_vld    (hi_vld),
      .start_evt (start_evt),
      .stop_evt  (stop_evt),
      .clr       (bc_clr),
      .byte_in   (byte_data),
      .in_code   (in_code),
      .word_done (word_done)
   );

   dac_out_latch #(.CODE_W(CODE_W)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (bc_clr),
      .stop_evt  (stop_evt),
      .bcast_upd (bc_upd),
      .word_done (word_done),
      .sync_mode (sy_mode),
      .sd_req    (cmd_q[I_SD]),
      .bg_req    (cmd_q[I_BG]),
      .in_code   (in_code),
      .dac_code  (dac_code),
      .shdn      (shdn),
      .ref_int   (ref_int)
   );
endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk #(
   parameter int CODE_W = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_evt,
   input logic              bcast_ack,
   input logic              bcast_flag,
   input logic              sync_mode,
   input logic [CODE_W-1:0] dac_code,
   input logic              shdn,
   input logic              ref_int
);
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_ack && !bcast_flag) |=> (dac_code == '0 && !shdn && !ref_int)); // R7

   AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_evt && !bcast_ack) |=> $stable(dac_code)); // R4

   AST_SYNC_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && sync_mode) |=> $stable(dac_code)); // R5

   AST_FLAG1_NOSYNC: assert property (@(posedge clk) disable iff (!rst_n)
      (bcast_ack && bcast_flag && !sync_mode) |=>
         ($stable(dac_code) && $stable(shdn) && $stable(ref_int))); // R6

   AST_CTRL_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_evt && !(bcast_ack && !bcast_flag)) |=> ($stable(shdn) && $stable(ref_int))); // R8
endmodule

bind dac_dbuf_ctrl dac_dbuf_chk #(.CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .stop_evt   (stop_evt),
   .bcast_ack  (bcast_ack),
   .bcast_flag (bcast_flag),
   .sync_mode  (sy_mode),
   .dac_code   (dac_code),
   .shdn       (shdn),
   .ref_int    (ref_int)
);

// File: tb/dac_dbuf_ctrl_tb.sv
`timescale 1ns/1ps
module dac_dbuf_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] byte_data = '0;
   logic       cmd_vld = 0, lo_vld = 0, hi_vld = 0;
   logic       start_evt = 0, stop_evt = 0, bcast_ack = 0, bcast_flag = 0;
   logic [9:0] dac_code;
   logic       shdn, ref_int;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit ended = 0;

   // behavioural reference state
   int m_cmd = 0, m_seq = 0, m_lo = 0, m_in = 0, m_out = 0;
   bit m_done = 0, m_shdn = 0, m_ref = 0;

   always #10 clk = ~clk;

   dac_dbuf_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .byte_data(byte_data),
      .cmd_vld(cmd_vld), .lo_vld(lo_vld), .hi_vld(hi_vld),
      .start_evt(start_evt), .stop_evt(stop_evt),
      .bcast_ack(bcast_ack), .bcast_flag(bcast_flag),
      .dac_code(dac_code), .shdn(shdn), .ref_int(ref_int)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_cmd = 0; m_seq = 0; m_lo = 0; m_in = 0; m_out = 0;
         m_done = 0; m_shdn = 0; m_ref = 0;
      end else if (bcast_ack && !bcast_flag) begin
         m_cmd = 0; m_seq = 0; m_lo = 0; m_in = 0; m_out = 0;
         m_done = 0; m_shdn = 0; m_ref = 0;
      end else if (stop_evt) begin
         m_shdn = ((m_cmd / 2) % 2) == 1;
         m_ref  = ((m_cmd / 4) % 2) == 1;
         if (m_done && (m_cmd % 2) == 0) m_out = m_in;
         m_done = 0; m_seq = 0;
      end else if (start_evt) begin
         m_seq = 0;
      end else if (cmd_vld) begin
         m_cmd = int'(byte_data) % 8; m_seq = 1; m_done = 0;
      end else if (lo_vld && m_seq == 1) begin
         m_lo = int'(byte_data); m_seq = 2;
      end else if (hi_vld && m_seq == 2) begin
         m_in = (int'(byte_data) % 4) * 256 + m_lo; m_done = 1; m_seq = 0;
      end else if (bcast_ack && bcast_flag && (m_cmd % 2) == 1) begin
         m_out = m_in;
      end
   end

   // per-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n && !ended) begin
         tests++;
         if (int'(dac_code) != m_out || shdn != m_shdn || ref_int != m_ref) begin
            fails++;
            $display("FAIL model R4 code=%0d/%0d shdn=%0b/%0b ref=%0b/%0b",
                     dac_code, m_out, shdn, m_shdn, ref_int, m_ref);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000 && !ended) begin
         ended = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // kinds: 0 cmd, 1 lo, 2 hi, 3 start, 4 stop, 5 bcast
   task automatic pulse(input int kind, input logic [7:0] b);
      @(negedge clk);
      byte_data = b;
      case (kind)
         0: cmd_vld = 1;
         1: lo_vld = 1;
         2: hi_vld = 1;
         3: start_evt = 1;
         4: stop_evt = 1;
         default: begin bcast_ack = 1; bcast_flag = b[0]; end
      endcase
      @(negedge clk);
      cmd_vld = 0; lo_vld = 0; hi_vld = 0; start_evt = 0; stop_evt = 0;
      bcast_ack = 0; bcast_flag = 0;
   endtask

   task automatic word(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi);
      pulse(3, 8'h00);
      pulse(0, c);
      pulse(1, lo);
      pulse(2, hi);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check("R1 code", int'(dac_code), 0);
      check("R1 shdn", int'(shdn), 0);
      check("R1 ref", int'(ref_int), 0);

      // STOP-mode write word, junk in high byte upper bits
      word(8'h00, 8'hA5, 8'hFE);
      check("R4 code before STOP", int'(dac_code), 0);
      pulse(4, 8'h00);
      check("R3 R4 code after STOP", int'(dac_code), 'h2A5);

      // control bits 7..3 set, mode unchanged
      word(8'hF8, 8'h3C, 8'h01);
      pulse(4, 8'h00);
      check("R2 upper control bits ignored", int'(dac_code), 'h13C);
      check("R2 shdn", int'(shdn), 0);

      // reference select by send-byte only
      pulse(3, 8'h00);
      pulse(0, 8'h04);
      check("R8 ref waits for STOP", int'(ref_int), 0);
      pulse(4, 8'h00);
      check("R2 ref selected", int'(ref_int), 1);
      check("R8 code kept", int'(dac_code), 'h13C);

      // shutdown and release
      pulse(3, 8'h00);
      pulse(0, 8'h06);
      pulse(4, 8'h00);
      check("R8 shutdown at STOP", int'(shdn), 1);
      check("R8 code retained in shutdown", int'(dac_code), 'h13C);
      pulse(3, 8'h00);
      pulse(0, 8'h04);
      pulse(4, 8'h00);
      check("R8 shutdown released", int'(shdn), 0);

      // broadcast flag 1 with sync off
      word(8'h04, 8'h77, 8'h02);
      pulse(5, 8'h01);
      check("R6 broadcast without sync", int'(dac_code), 'h13C);
      pulse(4, 8'h00);
      check("R4 STOP after broadcast", int'(dac_code), 'h277);

      // synchronous mode
      word(8'h05, 8'h55, 8'h03);
      pulse(4, 8'h00);
      check("R5 STOP holds in sync", int'(dac_code), 'h277);
      pulse(5, 8'h01);
      check("R5 broadcast loads", int'(dac_code), 'h355);

      // interrupted word: START after low byte
      pulse(3, 8'h00);
      pulse(0, 8'h02);
      pulse(1, 8'h11);
      pulse(3, 8'h00);
      pulse(4, 8'h00);
      check("R9 data dropped", int'(dac_code), 'h355);
      check("R9 control applied", int'(shdn), 1);
      check("R9 ref from control", int'(ref_int), 0);
      pulse(5, 8'h01);
      check("R9 no sync after sync bit cleared", int'(dac_code), 'h355);

      // clear while shutdown, ref and sync active
      word(8'h07, 8'h0F, 8'h01);
      pulse(4, 8'h00);
      check("R7 pre-clear ref", int'(ref_int), 1);
      pulse(5, 8'h00);
      check("R7 clear code", int'(dac_code), 0);
      check("R7 clear shdn", int'(shdn), 0);
      check("R7 clear ref", int'(ref_int), 0);
      pulse(5, 8'h01);
      check("R7 staged cleared and sync off", int'(dac_code), 0);

      repeat (3) @(negedge clk);
      if (!ended) begin
         ended = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule